// File: doc/BRIEF.md
# Calendar Alarm Comparator with Repeat Masks

This block sits beside a BCD real-time clock counter and watches for a programmed time of day. Software loads four alarm bytes (seconds, minutes, hours and day of month) through a byte-wide register port. On every one-second tick the block compares them with the running BCD time supplied by the external counter. When the comparison succeeds and the alarm is enabled, it produces a single-cycle interrupt pulse.

The top bit of each alarm byte is a mask flag. A small fixed set of mask patterns picks the repeat period. All clear gives once a month. Date masked alone gives once a day. Date and hours masked gives once an hour. Date, hours and minutes masked gives once a minute. Every other pattern fires on every tick. A write whose BCD value is out of range for its field is dropped, so the stored alarm stays valid.

Register map: address 0 seconds, 1 minutes, 2 hours, 3 date, 4 alarm control. Other addresses read as zero and ignore writes.

Top module: `calAlarm`

## Requirements
- R1: After reset the seconds, minutes and hours alarm registers read 0x00, the date register reads 0x01, the control register reads 0x00 and the interrupt is low.
- R2: An accepted write to an alarm register (addresses 0 to 3) is read back unchanged as the full byte, bit 7 mask flag included, and a rejected write leaves the previous byte readable.
- R3: A write to seconds (address 0) or minutes (address 1) is ignored when bits [6:0], decoded as high nibble times ten plus low nibble, exceed 59.
- R4: A write to hours (address 2) is ignored when bits [5:0], decoded the same way, exceed 23.
- R5: A write to date (address 3) is ignored when bits [4:0] decode to zero.
- R6: Comparison happens only in a cycle where the tick input is high. The interrupt rises at the clock edge that samples the tick and stays high for exactly that one cycle when the tick lasts one cycle.
- R7: With all four mask flags clear, the alarm fires only when seconds, minutes, hours and date all equal the current time (seconds and minutes on bits [6:0], hours on [5:0], date on [4:0]).
- R8: With only the date mask set, the alarm fires when seconds, minutes and hours match.
- R9: With the date and hours masks set and the others clear, the alarm fires when seconds and minutes match.
- R10: With the date, hours and minutes masks set and seconds clear, the alarm fires when seconds match.
- R11: Any other mask pattern fires the alarm on every tick, whatever the time.
- R12: Bit 7 of the control register (address 4) enables the interrupt. With it clear, no pulse is produced. The register reads back as bit 7 with bits [6:0] zero.
- R13: When a write to an alarm or control register falls in the same cycle as a tick, the comparison for that tick uses the values held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regAddr (combinational) |
| tick | input | 1 | One-second tick, one cycle wide |
| curSec | input | 7 | Current seconds, BCD |
| curMin | input | 7 | Current minutes, BCD |
| curHour | input | 6 | Current hours, BCD |
| curDate | input | 5 | Current day of month, BCD low bits |
| alarmIrq | output | 1 | Alarm interrupt pulse |

## Verification
A register write and a one-second tick can land on the same clock edge. The tick then has to be judged against the alarm bytes and enable bit as they stood before the write. The bench provokes this by writing a new seconds value while ticking with a time that matches only the old value. It expects a pulse on that tick and none on a later tick at the same time. A further tick at the new value must then fire. The range filter and the repeat masks are swept exhaustively: every byte value goes to every alarm field, and all sixteen mask patterns are tried against all sixteen patterns of field agreement.

// File: rtl/alarmPkg.sv
package alarmPkg;
  localparam int NUM_FIELDS = 4;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int CTRL_ADDR  = NUM_FIELDS;
  localparam int EN_BIT     = DATA_W - 1;

  typedef enum logic [2:0] {
    REP_MONTH, REP_DAY, REP_HOUR, REP_MINUTE, REP_SECOND
  } repMode_t;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] wrField;
    logic                  wrCtrl;
    logic [DATA_W-1:0]     data;
    logic                  tick;
  } strobes_t;

  // bits of each field that carry the BCD value
  function automatic logic [DATA_W-1:0] fieldMask(input int idx);
    case (idx)
      0, 1:    fieldMask = 8'h7F;
      2:       fieldMask = 8'h3F;
      default: fieldMask = 8'h1F;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] bcdValue(input logic [DATA_W-1:0] b);
    bcdValue = {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
  endfunction

  function automatic logic fieldOk(input int idx, input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] v;
    v = bcdValue(b & fieldMask(idx));
    case (idx)
      0, 1:    fieldOk = (v <= 8'd59);
      2:       fieldOk = (v <= 8'd23);
      default: fieldOk = (v != 8'd0);
    endcase
  endfunction
endpackage

// File: rtl/alarmCtrl.sv
module alarmCtrl
  import alarmPkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  output strobes_t          stb
);
  logic [NUM_FIELDS-1:0] fieldWr;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : gWrDec
    assign fieldWr[i] = wrEn && (regAddr == ADDR_W'(i)) && fieldOk(i, wrData);
  end

  always_comb begin
    stb.wrField = fieldWr;
    stb.wrCtrl  = wrEn && (regAddr == ADDR_W'(CTRL_ADDR));
    stb.data    = wrData;
    stb.tick    = tick;
  end
endmodule

// File: rtl/alarmDatapath.sv
module alarmDatapath
  import alarmPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              stb,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     curField [NUM_FIELDS],
  output logic [DATA_W-1:0]     rdData,
  output logic                  alarmIrq
);
  logic [DATA_W-1:0]     alReg [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fieldEq;
  logic [NUM_FIELDS-1:0] maskFlag;
  logic                  alarmEn;
  logic                  hit;
  repMode_t              mode;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : gField
    always_ff @(posedge clk) begin
      if (!rstN)                alReg[i] <= (i == NUM_FIELDS - 1) ? 8'h01 : 8'h00;
      else if (stb.wrField[i])  alReg[i] <= stb.data;
    end
    assign maskFlag[i] = alReg[i][DATA_W-1];
    assign fieldEq[i]  = ((alReg[i] ^ curField[i]) & fieldMask(i)) == '0;
  end

  // mask pattern {date, hour, min, sec} selects the repeat period
  always_comb begin
    case (maskFlag)
      4'b0000: mode = REP_MONTH;
      4'b1000: mode = REP_DAY;
      4'b1100: mode = REP_HOUR;
      4'b1110: mode = REP_MINUTE;
      default: mode = REP_SECOND;
    endcase
    case (mode)
      REP_MONTH:  hit = &fieldEq;
      REP_DAY:    hit = &fieldEq[2:0];
      REP_HOUR:   hit = &fieldEq[1:0];
      REP_MINUTE: hit = fieldEq[0];
      default:    hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmEn  <= 1'b0;
      alarmIrq <= 1'b0;
    end else begin
      if (stb.wrCtrl) alarmEn <= stb.data[EN_BIT];
      alarmIrq <= stb.tick && alarmEn && hit;
    end
  end

  always_comb begin
    if (int'(regAddr) < NUM_FIELDS)       rdData = alReg[regAddr[1:0]];
    else if (int'(regAddr) == CTRL_ADDR)  rdData = {alarmEn, 7'd0};
    else                                  rdData = '0;
  end

  // R6: a pulse always follows a tick
  a_r6_irq_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> $past(stb.tick));
  // R12: a pulse needs the enable as it stood at the tick
  a_r12_irq_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> $past(alarmEn));
  // R3: stored seconds and minutes stay in range
  a_r3_sec_range: assert property (@(posedge clk) disable iff (!rstN)
    bcdValue(alReg[0] & 8'h7F) <= 8'd59);
  a_r3_min_range: assert property (@(posedge clk) disable iff (!rstN)
    bcdValue(alReg[1] & 8'h7F) <= 8'd59);
  // R4: stored hours stay in range
  a_r4_hour_range: assert property (@(posedge clk) disable iff (!rstN)
    bcdValue(alReg[2] & 8'h3F) <= 8'd23);
  // R5: stored date never zero
  a_r5_date_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    bcdValue(alReg[3] & 8'h1F) != 8'd0);
endmodule

// File: rtl/calAlarm.sv
module calAlarm
  import alarmPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        tick,
  input  logic [6:0]  curSec,
  input  logic [6:0]  curMin,
  input  logic [5:0]  curHour,
  input  logic [4:0]  curDate,
  output logic        alarmIrq
);
  strobes_t          stb;
  logic [DATA_W-1:0] curField [NUM_FIELDS];

  assign curField[0] = {1'b0, curSec};
  assign curField[1] = {1'b0, curMin};
  assign curField[2] = {2'b0, curHour};
  assign curField[3] = {3'b0, curDate};

  alarmCtrl uCtrl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .wrData  (wrData),
    .tick    (tick),
    .stb     (stb)
  );

  alarmDatapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regAddr  (regAddr),
    .curField (curField),
    .rdData   (rdData),
    .alarmIrq (alarmIrq)
  );
endmodule

// File: tb/test_calAlarm.sv
module test_calAlarm;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       tick = 1'b0;
  logic [6:0] curSec = '0;
  logic [6:0] curMin = '0;
  logic [5:0] curHour = '0;
  logic [4:0] curDate = '0;
  logic       alarmIrq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  calAlarm i_calAlarm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .tick(tick), .curSec(curSec), .curMin(curMin),
    .curHour(curHour), .curDate(curDate), .alarmIrq(alarmIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int dec(input int b);
    return (b >> 4) * 10 + (b & 15);
  endfunction

  function automatic bit accepted(input int f, input int b);
    if (f < 2)  return dec(b & 8'h7F) <= 59;
    if (f == 2) return dec(b & 8'h3F) <= 23;
    return dec(b & 8'h1F) != 0;
  endfunction

  task automatic writeReg(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = 3'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input int a, output int d);
    regAddr = 3'(a);
    #1;
    d = int'(rdData);
  endtask

  // one-cycle tick with given time, checks pulse and its release
  task automatic doTick(input int s, input int m, input int h, input int dt,
                        input int exp, input string req);
    @(negedge clk);
    curSec = 7'(s); curMin = 7'(m); curHour = 6'(h); curDate = 5'(dt);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(req, int'(alarmIrq), exp);
    @(negedge clk);
    check({req, " R6 release"}, int'(alarmIrq), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rd;
    int held;
    int alarmV [4];
    int nextV [4];
    alarmV = '{8'h30, 8'h15, 8'h12, 8'h07};
    nextV  = '{8'h31, 8'h16, 8'h13, 8'h08};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 5; a++) begin
      readReg(a, rd);
      check("R1 reset value", rd, (a == 3) ? 1 : 0);
    end
    check("R1 irq low", int'(alarmIrq), 0);

    // R2-R5 exhaustive write sweep per field
    for (int f = 0; f < 4; f++) begin
      readReg(f, held);
      for (int v = 0; v < 256; v++) begin
        writeReg(f, v);
        if (accepted(f, v)) held = v;
        readReg(f, rd);
        case (f)
          0, 1: check("R3 R2 sec/min filter", rd, held);
          2:    check("R4 R2 hour filter", rd, held);
          default: check("R5 R2 date filter", rd, held);
        endcase
      end
    end

    // R12 control readback
    writeReg(4, 8'h7F);
    readReg(4, rd);
    check("R12 ctrl readback low bits", rd, 0);
    writeReg(4, 8'h80);
    readReg(4, rd);
    check("R12 ctrl readback enable", rd, 8'h80);

    // R7-R11 mask pattern x field agreement sweep
    for (int mk = 0; mk < 16; mk++) begin
      for (int f = 0; f < 4; f++)
        writeReg(f, alarmV[f] | (((mk >> f) & 1) << 7));
      for (int df = 0; df < 16; df++) begin
        bit eq [4];
        int exp;
        string req;
        for (int f = 0; f < 4; f++) eq[f] = ((df >> f) & 1) == 0;
        case (mk)
          0:  begin exp = eq[0] && eq[1] && eq[2] && eq[3]; req = "R7 monthly"; end
          8:  begin exp = eq[0] && eq[1] && eq[2]; req = "R8 daily"; end
          12: begin exp = eq[0] && eq[1]; req = "R9 hourly"; end
          14: begin exp = eq[0]; req = "R10 minutely"; end
          default: begin exp = 1; req = "R11 every tick"; end
        endcase
        doTick(eq[0] ? alarmV[0] : nextV[0], eq[1] ? alarmV[1] : nextV[1],
               eq[2] ? alarmV[2] : nextV[2], eq[3] ? alarmV[3] : nextV[3], exp, req);
      end
    end

    // R6 no compare without tick: matching time held, no tick
    for (int f = 0; f < 4; f++) writeReg(f, alarmV[f]);
    curSec = 7'h30; curMin = 7'h15; curHour = 6'h12; curDate = 5'h07;
    repeat (4) begin
      @(negedge clk);
      check("R6 no tick no irq", int'(alarmIrq), 0);
    end

    // R12 disabled: exact match gives no pulse
    writeReg(4, 8'h00);
    doTick(8'h30, 8'h15, 8'h12, 8'h07, 0, "R12 disabled");
    writeReg(4, 8'h80);
    doTick(8'h30, 8'h15, 8'h12, 8'h07, 1, "R12 enabled R7");

    // R13 write and tick on the same edge, minutely mode
    writeReg(1, 8'h95); writeReg(2, 8'h92); writeReg(3, 8'h87);
    @(negedge clk);
    curSec = 7'h30; wrEn = 1'b1; regAddr = 3'd0; wrData = 8'h40; tick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
    check("R13 old value compared", int'(alarmIrq), 1);
    doTick(8'h30, 8'h15, 8'h12, 8'h07, 0, "R13 new value in force");
    doTick(8'h40, 8'h15, 8'h12, 8'h07, 1, "R13 new value fires");
    // R13 disable written on a matching tick: old enable used
    @(negedge clk);
    curSec = 7'h40; wrEn = 1'b1; regAddr = 3'd4; wrData = 8'h00; tick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
    check("R13 old enable used", int'(alarmIrq), 1);
    doTick(8'h40, 8'h15, 8'h12, 8'h07, 0, "R13 R12 now disabled");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule